// File: doc/BRIEF.md
# Two-Word Instruction Fetch Predecoder

The predecoder sits between program memory and the execute stage of an 8-bit RISC core. It accepts 16-bit instruction words one at a time through a valid/ready port. For each instruction it sends out one complete record, which holds the first word, an operand word, a length flag and a one-hot class vector.

Four opcode families take a second 16-bit word: far call, far jump, direct data load and direct data store. The block recognises them with masked compares. When it sees the first word of such an instruction, it holds that word and produces nothing until the next accepted word arrives, which becomes the operand.

Thirteen fixed no-operand opcodes are matched exactly and each one gets its own class bit. Any other word goes out as a single-word instruction of class "other". A flush input drops a held first word.

Top module: `iword_predec`

## Requirements
- R1: After reset `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: A word with `(w & 0xFE0E) == 0x940E` is a far call (class bit 14), and one with `(w & 0xFE0E) == 0x940C` is a far jump (class bit 15). Each is emitted with `out_len2_o`=1, `out_word_o` = the first word and `out_operand_o` = the next accepted word.
- R3: A word with `(w & 0xFE0F) == 0x9000` is a direct load (class bit 16), and one with `(w & 0xFE0F) == 0x9200` is a direct store (class bit 17). Both are emitted as two-word instructions in the same way as R2.
- R4: These exact words set the class bit shown: 0x0000→1, 0x9508→2, 0x9518→3, 0x9509→4, 0x9409→5, 0x9519→6, 0x9419→7, 0x9588→8, 0x95A8→9, 0x9598→10, 0x95C8→11, 0x95D8→12, 0x95E8→13. Each is emitted as a single-word instruction.
- R5: A word that matches no pattern is emitted as a single-word instruction with class bit 0 ("other").
- R6: The second word of a two-word instruction is never classified on its own, even when it matches a two-word pattern. The word after it starts a new instruction.
- R7: While a first word is held, `out_valid_o` stays 0. The record appears in the cycle after the second word is accepted.
- R8: When `flush_i` is high, any held first word is discarded and no input is accepted. The next accepted word is classified as a new instruction.
- R9: While `out_valid_o`=1 and `out_ready_i`=0, all output fields stay stable and `in_ready_o` is 0.
- R10: A single-word record appears in the cycle after its word is accepted, with `out_len2_o`=0 and `out_operand_o`=0.
- R11: Whenever `out_valid_o` is 1, exactly one bit of `out_cls_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard held first word |
| in_valid_i | input | 1 | Input word valid |
| in_word_i | input | 16 | Instruction word from program memory |
| in_ready_o | output | 1 | Input word accepted this cycle when high with valid |
| out_valid_o | output | 1 | Instruction record valid |
| out_ready_i | input | 1 | Execute stage takes the record |
| out_word_o | output | 16 | First instruction word |
| out_operand_o | output | 16 | Second word, zero for single-word records |
| out_len2_o | output | 1 | Record is a two-word instruction |
| out_cls_o | output | 18 | One-hot class vector |

## Verification
The bench feeds an operand word that itself matches the far-call pattern. A design that classified second words would then emit a spurious record and misalign every instruction after it.

It flushes between a held first word and a fresh single word. A design that kept the held word would then pair the two into one bogus two-word record.

It stalls the output with a new word waiting at the input. A design that consumed input during the stall would overwrite or lose a record.

A long mixed stream under a pseudo-random ready pattern catches off-by-one mask bits, for example 0x940F, which must still count as a far call.

// File: rtl/predec_pkg.sv
package predec_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [4:0] {
    CLS_OTHER     = 5'd0,
    CLS_IDLE_OP   = 5'd1,
    CLS_SUB_RET   = 5'd2,
    CLS_INT_RET   = 5'd3,
    CLS_IND_CALL  = 5'd4,
    CLS_IND_JUMP  = 5'd5,
    CLS_XIND_CALL = 5'd6,
    CLS_XIND_JUMP = 5'd7,
    CLS_SLEEP     = 5'd8,
    CLS_WDOG      = 5'd9,
    CLS_BRK       = 5'd10,
    CLS_PM_LOAD   = 5'd11,
    CLS_XPM_LOAD  = 5'd12,
    CLS_PM_STORE  = 5'd13,
    CLS_FAR_CALL  = 5'd14,
    CLS_FAR_JUMP  = 5'd15,
    CLS_DIR_LOAD  = 5'd16,
    CLS_DIR_STORE = 5'd17
  } cls_e;

  localparam int NCLS = 18;
  localparam int FIRST_LONG = 14;

  function automatic logic [WORD_W-1:0] pat_val(input int idx);
    case (idx)
      1:       return 16'h0000;
      2:       return 16'h9508;
      3:       return 16'h9518;
      4:       return 16'h9509;
      5:       return 16'h9409;
      6:       return 16'h9519;
      7:       return 16'h9419;
      8:       return 16'h9588;
      9:       return 16'h95A8;
      10:      return 16'h9598;
      11:      return 16'h95C8;
      12:      return 16'h95D8;
      13:      return 16'h95E8;
      14:      return 16'h940E;
      15:      return 16'h940C;
      16:      return 16'h9000;
      17:      return 16'h9200;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pat_msk(input int idx);
    if (idx == 14 || idx == 15) return 16'hFE0E;
    if (idx == 16 || idx == 17) return 16'hFE0F;
    return 16'hFFFF;
  endfunction

  function automatic logic [NCLS-1:0] long_vec();
    logic [NCLS-1:0] v;
    v = '0;
    for (int i = FIRST_LONG; i < NCLS; i++) v[i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/predec_classify.sv
module predec_classify
  import predec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [NCLS-1:0]   cls_o,
  output logic              long_o
);
  localparam logic [NCLS-1:0] LONG_MASK = long_vec();

  logic [NCLS-1:0] match;

  assign match[0] = 1'b0;
  for (genvar g = 1; g < NCLS; g++) begin : g_pat
    localparam logic [WORD_W-1:0] MSK = pat_msk(g);
    localparam logic [WORD_W-1:0] VAL = pat_val(g);
    assign match[g] = ((word_i & MSK) == VAL);
  end

  assign cls_o  = {match[NCLS-1:1], ~|match[NCLS-1:1]};
  assign long_o = |(match & LONG_MASK);
endmodule

// File: rtl/predec_assemble.sv
module predec_assemble
  import predec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic [NCLS-1:0]   in_cls_i,
  input  logic              in_long_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_word_o,
  output logic [WORD_W-1:0] out_operand_o,
  output logic              out_len2_o,
  output logic [NCLS-1:0]   out_cls_o
);
  typedef enum logic {ST_IDLE, ST_HOLD} st_e;

  st_e               state_q;
  logic [WORD_W-1:0] hold_word_q;
  logic [NCLS-1:0]   hold_cls_q;
  logic              accept, load_out;

  assign in_ready_o = ~flush_i & (~out_valid_o | out_ready_i);
  assign accept     = in_valid_i & in_ready_o;
  assign load_out   = accept & ((state_q == ST_HOLD) | ~in_long_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      hold_word_q <= '0;
      hold_cls_q  <= '0;
    end else if (flush_i) begin
      state_q <= ST_IDLE;
    end else if (accept) begin
      if (state_q == ST_IDLE && in_long_i) begin
        hold_word_q <= in_word_i;
        hold_cls_q  <= in_cls_i;
        state_q     <= ST_HOLD;
      end else begin
        state_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o   <= 1'b0;
      out_word_o    <= '0;
      out_operand_o <= '0;
      out_len2_o    <= 1'b0;
      out_cls_o     <= '0;
    end else if (load_out) begin
      out_valid_o <= 1'b1;
      if (state_q == ST_HOLD) begin
        out_word_o    <= hold_word_q;
        out_operand_o <= in_word_i;
        out_len2_o    <= 1'b1;
        out_cls_o     <= hold_cls_q;
      end else begin
        out_word_o    <= in_word_i;
        out_operand_o <= '0;
        out_len2_o    <= 1'b0;
        out_cls_o     <= in_cls_i;
      end
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_word_o) &&
      $stable(out_operand_o) && $stable(out_len2_o) && $stable(out_cls_o)); // R9
  AST_STALL_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R9
  AST_CLS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones(out_cls_o) == 1); // R11
  AST_FLUSH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> state_q == ST_IDLE); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOLD && !accept && !out_valid_o |=> !out_valid_o); // R7
  AST_SINGLE_ZERO_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_len2_o |-> out_operand_o == '0); // R10
endmodule

// File: rtl/iword_predec.sv
module iword_predec
  import predec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_word_o,
  output logic [WORD_W-1:0] out_operand_o,
  output logic              out_len2_o,
  output logic [NCLS-1:0]   out_cls_o
);
  logic [NCLS-1:0] cls;
  logic            is_long;

  predec_classify u_cls (
    .word_i (in_word_i),
    .cls_o  (cls),
    .long_o (is_long)
  );

  predec_assemble u_asm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .in_valid_i    (in_valid_i),
    .in_word_i     (in_word_i),
    .in_cls_i      (cls),
    .in_long_i     (is_long),
    .in_ready_o    (in_ready_o),
    .out_valid_o   (out_valid_o),
    .out_ready_i   (out_ready_i),
    .out_word_o    (out_word_o),
    .out_operand_o (out_operand_o),
    .out_len2_o    (out_len2_o),
    .out_cls_o     (out_cls_o)
  );
endmodule

// File: tb/iword_predec_tb_top.sv
module iword_predec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = 16'h0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_word, out_operand;
  logic        out_len2;
  logic [17:0] out_cls;

  int total = 0;
  int bad = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_tag = "R5";

  typedef struct {
    logic [15:0] w;
    logic [15:0] op;
    logic        len2;
    logic [17:0] cls;
    string       tag;
  } item_t;
  item_t sb[$];

  bit          pend = 1'b0;
  logic [15:0] pend_w;
  logic [17:0] pend_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  iword_predec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .in_valid_i(in_valid), .in_word_i(in_word), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_word_o(out_word), .out_operand_o(out_operand),
    .out_len2_o(out_len2), .out_cls_o(out_cls)
  );

  function automatic int exp_idx(input logic [15:0] w);
    case (w)
      16'h0000: return 1;  16'h9508: return 2;  16'h9518: return 3;
      16'h9509: return 4;  16'h9409: return 5;  16'h9519: return 6;
      16'h9419: return 7;  16'h9588: return 8;  16'h95A8: return 9;
      16'h9598: return 10; 16'h95C8: return 11; 16'h95D8: return 12;
      16'h95E8: return 13;
      default: ;
    endcase
    if ((w & 16'hFE0E) == 16'h940E) return 14;
    if ((w & 16'hFE0E) == 16'h940C) return 15;
    if ((w & 16'hFE0F) == 16'h9000) return 16;
    if ((w & 16'hFE0F) == 16'h9200) return 17;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // scoreboard model of a word accepted at the input
  task automatic model_accept(input logic [15:0] w);
    item_t it;
    int k;
    if (pend) begin
      it = '{pend_w, w, 1'b1, pend_c, cur_tag};
      sb.push_back(it);
      pend = 1'b0;
    end else begin
      k = exp_idx(w);
      if (k >= 14) begin
        pend = 1'b1; pend_w = w; pend_c = 18'd1 << k;
      end else begin
        it = '{w, 16'h0, 1'b0, 18'd1 << k, cur_tag};
        sb.push_back(it);
      end
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic send(input logic [15:0] w);
    bit acc;
    in_valid = 1'b1;
    in_word  = w;
    do begin
      #2 acc = in_ready;
      if (acc) model_accept(w);
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    pend = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (sb.size() != 0 && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'b0;
      default: out_ready = lfsr[3] | lfsr[7];
    endcase
  end

  // monitor
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6", "unexpected record word", {16'h0, out_word}, 32'h0);
        end else begin
          e = sb.pop_front();
          check(out_word == e.w, e.tag, "word", {16'h0, out_word}, {16'h0, e.w});
          check(out_operand == e.op, e.tag, "operand", {16'h0, out_operand}, {16'h0, e.op});
          check(out_len2 == e.len2, e.tag, "len2", {31'h0, out_len2}, {31'h0, e.len2});
          check(out_cls == e.cls, e.tag, "class", {14'h0, out_cls}, {14'h0, e.cls});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] exact [13];
    exact = '{16'h0000, 16'h9508, 16'h9518, 16'h9509, 16'h9409, 16'h9519, 16'h9419,
              16'h9588, 16'h95A8, 16'h9598, 16'h95C8, 16'h95D8, 16'h95E8};
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1", "valid in reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R1", "ready in reset", {31'h0, in_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1", "valid after reset", {31'h0, out_valid}, 32'h0);

    // R4 every exact code
    cur_tag = "R4";
    for (int i = 0; i < 13; i++) send(exact[i]);
    drain();

    // R5 near misses and plain words
    cur_tag = "R5";
    send(16'h1234); send(16'h9408); send(16'h95F8); send(16'hFFFF);
    drain();

    // R2 far call / jump including masked bits
    cur_tag = "R2";
    send(16'h940E); send(16'hBEEF);
    send(16'h95FF); send(16'h0102);
    send(16'h940C); send(16'h0000);
    send(16'h95FD); send(16'h7777);
    drain();

    // R3 direct load / store
    cur_tag = "R3";
    send(16'h9000); send(16'h0100);
    send(16'h91F0); send(16'h2222);
    send(16'h9200); send(16'h0200);
    send(16'h93F0); send(16'h3333);
    drain();

    // R6 operand matches a long pattern
    cur_tag = "R6";
    send(16'h940E); send(16'h940E); send(16'h9508);
    send(16'h9000); send(16'h9200); send(16'h1111);
    drain();

    // R7 held first word produces nothing
    cur_tag = "R7";
    send(16'h940C);
    #2 check(out_valid == 1'b0, "R7", "valid while held", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    #2 check(out_valid == 1'b0, "R7", "valid while held 2", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    send(16'h4321);
    #2 check(out_valid == 1'b1, "R7", "valid after second", {31'h0, out_valid}, 32'h1);
    drain();

    // R8 flush drops held word
    cur_tag = "R8";
    send(16'h940E);
    do_flush();
    send(16'h5555);
    drain();
    in_valid = 1'b1; in_word = 16'h9598; flush = 1'b1;
    #2 check(in_ready == 1'b0, "R8", "ready during flush", {31'h0, in_ready}, 32'h0);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0; pend = 1'b0;
    @(negedge clk);
    #2 check(out_valid == 1'b0, "R8", "word taken during flush", {31'h0, out_valid}, 32'h0);
    @(negedge clk);

    // R10 single word latency
    cur_tag = "R10";
    send(16'h95A8);
    #2 check(out_valid == 1'b1 && out_operand == 16'h0 && out_len2 == 1'b0, "R10",
             "single next cycle", {15'h0, out_valid, out_operand}, 32'h10000);
    drain();

    // R9 stall
    cur_tag = "R9";
    rdy_mode = 1;
    @(negedge clk);
    send(16'h6789);
    in_valid = 1'b1; in_word = 16'h9518;
    for (int i = 0; i < 3; i++) begin
      #2;
      check(out_valid == 1'b1 && out_word == 16'h6789, "R9", "held word",
            {15'h0, out_valid, out_word}, 32'h16789);
      check(in_ready == 1'b0, "R9", "ready in stall", {31'h0, in_ready}, 32'h0);
      @(negedge clk);
    end
    rdy_mode = 0;
    @(negedge clk);
    model_accept(16'h9518);
    in_valid = 1'b0;
    drain();

    // R11 mixed stream with random ready
    cur_tag = "R11";
    rdy_mode = 2;
    for (int i = 0; i < 300; i++) begin
      case (lfsr[2:0])
        3'd0: send(16'h940E ^ {7'h0, lfsr[8:4], 3'h0, lfsr[9]});
        3'd1: send(16'h9000 | {7'h0, lfsr[10], 4'h0, lfsr[14:11]} & 16'h01F0);
        3'd2: send(exact[lfsr[11:8] % 13]);
        default: send(lfsr ^ 16'h5A5A);
      endcase
    end
    send(16'h0000);
    send(16'h0000);
    rdy_mode = 0;
    drain();
    check(sb.size() == 0, "R11", "leftover records", sb.size(), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule